// File: doc/BRIEF.md
# Accumulator Register-Operation Executor

This block carries out the twelve accumulator-and-link operations of a 16-bit accumulator machine. It holds the accumulator, the one-bit link register beside it, and the run flag. When the control sequencer reaches the decode-complete step, it presents the instruction's low twelve bits together with three qualifiers: the opcode-all-ones decode, the indirect bit and the step-3 timing strobe. Each operation is chosen by a single bit of the 12-bit field. The block then does one of three things in that same cycle. It may update the accumulator and link, request one extra program-counter increment to skip the next instruction, or drop the run flag to stop the machine.

The skip request and the sequence-counter clear are combinational. They are valid in the cycle the operation is enabled, so the sequencer consumes them on the same edge that commits the register update. Once the run flag is low, the sequencer must stop its step counter. Only the external start input raises the flag again. All pins are plain control and status lines. The block exchanges no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `rr_exec`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator reads 0, the link reads 0, the run flag reads 1, and neither skip nor counter-clear is asserted.
- R2: An operation is enabled only when the all-ones decode is 1, the indirect bit is 0, the step-3 strobe is 1 and the run flag is 1. Counter-clear is 1 in exactly the enabled cycles. In any other cycle the accumulator, link and run flag keep their values.
- R3: Field bit 11 (code 0x800, full word 0x7800) clears the accumulator. Bit 10 (0x400) clears the link.
- R4: Bit 9 (0x200) inverts every accumulator bit. Bit 8 (0x100) inverts the link.
- R5: Bit 7 (0x080) rotates the 17-bit pair {accumulator, link} right: the link enters accumulator bit 15 and accumulator bit 0 enters the link. Bit 6 (0x040) rotates left: the link enters bit 0 and bit 15 enters the link.
- R6: Bit 5 (0x020) adds one to the accumulator modulo 2^16 and leaves the link unchanged.
- R7: The skip output goes high in the enabled cycle, and the registers stay unchanged, under four conditions. Bit 4 (0x010) skips when accumulator bit 15 is 0. Bit 3 (0x008) skips when bit 15 is 1. Bit 2 (0x004) skips when all 16 accumulator bits are 0. Bit 1 (0x002) skips when the link is 0.
- R8: Bit 0 (0x001) clears the run flag. While the flag is low, every request is ignored: no counter-clear, no skip, no register change. Start sets the flag on the next edge, and start wins over a halt in the same cycle.
- R9: A field with no bit set, or with more than one bit set, changes nothing and produces no skip, but counter-clear is still asserted.
- R10: Accumulator, link and run flag change on the clock edge that ends the enabled cycle. Skip and counter-clear are combinational in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d7_i | input | 1 | Opcode decode output for the all-ones opcode |
| ind_i | input | 1 | Indirect bit of the instruction |
| t3_i | input | 1 | Step-3 timing strobe |
| ir_i | input | 12 | Low twelve instruction bits, one bit per operation |
| start_i | input | 1 | External start, raises the run flag |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Link register |
| run_o | output | 1 | Run flag; low stops the step counter |
| pc_inc_o | output | 1 | Extra program-counter increment (skip) |
| sc_clr_o | output | 1 | Clear the sequence counter |

## Verification
Skip and counter-clear are due in the enabled cycle itself. Accumulator, link and run flag are due one edge later. Each stimulus is applied just after a falling edge, and the combinational outputs are sampled one nanosecond later, before the next rising edge. The reference model is then advanced, and the registered outputs are compared at the following falling edge. Every output is compared on every step.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
  localparam int DATA_W = 16;
  localparam int FIELD_W = 12;
  // bit positions decoded by the executor (behaviour depends on them)
  localparam int OP_CLR_ACC = 11;
  localparam int OP_CLR_LNK = 10;
  localparam int OP_INV_ACC = 9;
  localparam int OP_INV_LNK = 8;
  localparam int OP_ROT_R   = 7;
  localparam int OP_ROT_L   = 6;
  localparam int OP_BUMP    = 5;
  localparam int OP_SK_POS  = 4;
  localparam int OP_SK_NEG  = 3;
  localparam int OP_SK_ZAC  = 2;
  localparam int OP_SK_ZLK  = 1;
  localparam int OP_STOP    = 0;
  localparam int ALU_OPS    = OP_CLR_ACC - OP_BUMP + 1;
  localparam int SKIP_OPS   = OP_SK_POS - OP_SK_ZLK + 1;
endpackage

// File: rtl/rr_decode.sv
`timescale 1ns/1ps
module rr_decode #(
  parameter int FW = rr_pkg::FIELD_W
) (
  input  logic          en_i,
  input  logic [FW-1:0] field_i,
  output logic [FW-1:0] sel_o
);
  localparam int CNT_W = $clog2(FW + 1);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < FW; i++) ones = ones + CNT_W'(field_i[i]);
  end

  // only a single selected operation is honoured
  assign sel_o = (en_i && ones == CNT_W'(1)) ? field_i : '0;
endmodule

// File: rtl/rr_acc_unit.sv
`timescale 1ns/1ps
module rr_acc_unit #(
  parameter int DW = rr_pkg::DATA_W
) (
  input  logic [rr_pkg::ALU_OPS-1:0] sel_i,   // field bits 11..5
  input  logic [DW-1:0]              ac_i,
  input  logic                       e_i,
  output logic [DW-1:0]              ac_o,
  output logic                       e_o
);
  import rr_pkg::*;
  localparam int BASE = OP_BUMP;

  always_comb begin
    ac_o = ac_i;
    e_o  = e_i;
    if (sel_i[OP_CLR_ACC-BASE]) ac_o = '0;
    else if (sel_i[OP_CLR_LNK-BASE]) e_o = 1'b0;
    else if (sel_i[OP_INV_ACC-BASE]) ac_o = ~ac_i;
    else if (sel_i[OP_INV_LNK-BASE]) e_o = ~e_i;
    else if (sel_i[OP_ROT_R-BASE]) begin
      ac_o = {e_i, ac_i[DW-1:1]};
      e_o  = ac_i[0];
    end else if (sel_i[OP_ROT_L-BASE]) begin
      ac_o = {ac_i[DW-2:0], e_i};
      e_o  = ac_i[DW-1];
    end else if (sel_i[OP_BUMP-BASE]) ac_o = ac_i + DW'(1);
  end
endmodule

// File: rtl/rr_skip.sv
`timescale 1ns/1ps
module rr_skip #(
  parameter int DW = rr_pkg::DATA_W
) (
  input  logic [rr_pkg::SKIP_OPS-1:0] sel_i,   // field bits 4..1
  input  logic [DW-1:0]               ac_i,
  input  logic                        e_i,
  output logic                        skip_o
);
  import rr_pkg::*;
  localparam int BASE = OP_SK_ZLK;
  logic [SKIP_OPS-1:0] cond;

  always_comb begin
    cond = '0;
    cond[OP_SK_POS-BASE] = ~ac_i[DW-1];
    cond[OP_SK_NEG-BASE] =  ac_i[DW-1];
    cond[OP_SK_ZAC-BASE] = (ac_i == '0);
    cond[OP_SK_ZLK-BASE] = ~e_i;
  end

  assign skip_o = |(sel_i & cond);
endmodule

// File: rtl/rr_exec.sv
`timescale 1ns/1ps
module rr_exec #(
  parameter int DW = rr_pkg::DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       d7_i,
  input  logic                       ind_i,
  input  logic                       t3_i,
  input  logic [rr_pkg::FIELD_W-1:0] ir_i,
  input  logic                       start_i,
  output logic [DW-1:0]              ac_o,
  output logic                       e_o,
  output logic                       run_o,
  output logic                       pc_inc_o,
  output logic                       sc_clr_o
);
  import rr_pkg::*;

  logic [DW-1:0]      ac_q, ac_d;
  logic               e_q, e_d, run_q;
  logic               fire;
  logic [FIELD_W-1:0] sel;

  assign fire = d7_i & ~ind_i & t3_i & run_q;

  rr_decode #(.FW(FIELD_W)) u_dec (
    .en_i(fire), .field_i(ir_i), .sel_o(sel)
  );

  rr_acc_unit #(.DW(DW)) u_acc (
    .sel_i(sel[OP_CLR_ACC:OP_BUMP]), .ac_i(ac_q), .e_i(e_q),
    .ac_o(ac_d), .e_o(e_d)
  );

  rr_skip #(.DW(DW)) u_skip (
    .sel_i(sel[OP_SK_POS:OP_SK_ZLK]), .ac_i(ac_q), .e_i(e_q),
    .skip_o(pc_inc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q  <= '0;
      e_q   <= 1'b0;
      run_q <= 1'b1;
    end else begin
      ac_q <= ac_d;
      e_q  <= e_d;
      if (start_i) run_q <= 1'b1;
      else if (sel[OP_STOP]) run_q <= 1'b0;
    end
  end

  assign ac_o     = ac_q;
  assign e_o      = e_q;
  assign run_o    = run_q;
  assign sc_clr_o = fire;
endmodule

// File: rtl/rr_exec_chk.sv
`timescale 1ns/1ps
module rr_exec_chk #(
  parameter int DW = rr_pkg::DATA_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       d7_i,
  input logic                       ind_i,
  input logic                       t3_i,
  input logic [rr_pkg::FIELD_W-1:0] ir_i,
  input logic                       start_i,
  input logic [DW-1:0]              ac_o,
  input logic                       e_o,
  input logic                       run_o,
  input logic                       pc_inc_o,
  input logic                       sc_clr_o
);
  assert_clear_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_clr_o |-> (d7_i && !ind_i && t3_i && run_o));

  assert_clear_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clr_o && ir_i == 12'h800) |=> (ac_o == '0));

  assert_rotate_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clr_o && ir_i == 12'h080) |=>
      (ac_o == {$past(e_o), $past(ac_o[DW-1:1])} && e_o == $past(ac_o[0])));

  assert_bump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clr_o && ir_i == 12'h020) |=> (ac_o == $past(ac_o) + DW'(1) && $stable(e_o)));

  assert_skip_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_o |=> ($stable(ac_o) && $stable(e_o)));

  assert_skip_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc_o |-> sc_clr_o);

  assert_halt_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !start_i) |=> (!run_o && $stable(ac_o) && $stable(e_o)));

  assert_multi_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clr_o && $countones(ir_i) != 1) |=> ($stable(ac_o) && $stable(e_o)));
endmodule

bind rr_exec rr_exec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .d7_i(d7_i), .ind_i(ind_i), .t3_i(t3_i),
  .ir_i(ir_i), .start_i(start_i), .ac_o(ac_o), .e_o(e_o), .run_o(run_o),
  .pc_inc_o(pc_inc_o), .sc_clr_o(sc_clr_o)
);

// File: tb/tb_rr_exec.sv
`timescale 1ns/1ps
module tb_rr_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d7_i = 1'b0, ind_i = 1'b0, t3_i = 1'b0, start_i = 1'b0;
  logic [11:0] ir_i = '0;
  logic [15:0] ac_o;
  logic        e_o, run_o, pc_inc_o, sc_clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int unsigned m_ac = 0;
  bit m_e = 0;
  bit m_run = 1;

  always #2 clk = ~clk;

  rr_exec dut (
    .clk(clk), .rst_n(rst_n), .d7_i(d7_i), .ind_i(ind_i), .t3_i(t3_i),
    .ir_i(ir_i), .start_i(start_i), .ac_o(ac_o), .e_o(e_o), .run_o(run_o),
    .pc_inc_o(pc_inc_o), .sc_clr_o(sc_clr_o)
  );

  task automatic check(string req, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // apply one cycle of stimulus, compare every output, advance the model
  task automatic step(string req, bit d7, bit ind, bit t3, logic [11:0] f, bit st);
    bit en, one, sk;
    int unsigned a;
    d7_i = d7; ind_i = ind; t3_i = t3; ir_i = f; start_i = st;
    #1;
    en  = d7 && !ind && t3 && m_run;
    one = $countones(f) == 1;
    a   = m_ac;
    sk  = 0;
    if (en && one) begin
      if (f == 12'h010 && a < 32768) sk = 1;
      if (f == 12'h008 && a >= 32768) sk = 1;
      if (f == 12'h004 && a == 0) sk = 1;
      if (f == 12'h002 && !m_e) sk = 1;
    end
    check(req, "ac", ac_o, m_ac);
    check(req, "link", e_o, m_e);
    check(req, "run", run_o, m_run);
    check(req, "skip", pc_inc_o, sk);
    check(req, "clear", sc_clr_o, en);
    if (en && one) begin
      case (f)
        12'h800: m_ac = 0;
        12'h400: m_e = 0;
        12'h200: m_ac = 16'hFFFF - a;
        12'h100: m_e = !m_e;
        12'h080: begin m_ac = a / 2 + (m_e ? 32768 : 0); m_e = a % 2; end
        12'h040: begin m_ac = (a * 2) % 65536 + (m_e ? 1 : 0); m_e = a >= 32768; end
        12'h020: m_ac = (a + 1) % 65536;
        default: ;
      endcase
    end
    if (st) m_run = 1;
    else if (en && f == 12'h001) m_run = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset values while held
    check("R1", "ac", ac_o, 0);
    check("R1", "run", run_o, 1);
    check("R1", "clear", sc_clr_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 0, 12'h000, 0);
    step("R4", 1, 0, 1, 12'h200, 0);  // acc -> FFFF
    step("R7", 1, 0, 1, 12'h008, 0);  // negative: skip
    step("R7", 1, 0, 1, 12'h010, 0);  // not positive
    step("R6", 1, 0, 1, 12'h020, 0);  // wrap to 0
    step("R7", 1, 0, 1, 12'h004, 0);  // zero: skip
    step("R7", 1, 0, 1, 12'h002, 0);  // link 0: skip
    step("R4", 1, 0, 1, 12'h100, 0);  // link -> 1
    step("R7", 1, 0, 1, 12'h002, 0);  // link 1: no skip
    step("R5", 1, 0, 1, 12'h080, 0);  // 8000, link 0
    step("R5", 1, 0, 1, 12'h040, 0);  // 0000, link 1
    step("R5", 1, 0, 1, 12'h040, 0);  // 0001, link 0
    step("R4", 1, 0, 1, 12'h200, 0);  // FFFE
    step("R5", 1, 0, 1, 12'h080, 0);  // 7FFF, link 0
    step("R7", 1, 0, 1, 12'h010, 0);  // positive: skip
    step("R7", 1, 0, 1, 12'h004, 0);  // nonzero: no skip
    step("R6", 1, 0, 1, 12'h020, 0);  // 8000
    step("R4", 1, 0, 1, 12'h100, 0);  // link 1
    step("R3", 1, 0, 1, 12'h400, 0);  // link 0
    step("R4", 1, 0, 1, 12'h100, 0);  // link 1
    step("R3", 1, 0, 1, 12'h800, 0);  // acc 0
    step("R3", 1, 0, 1, 12'h400, 0);
    step("R2", 1, 0, 0, 12'h200, 0);  // no strobe
    step("R2", 1, 1, 1, 12'h200, 0);  // indirect set
    step("R2", 0, 0, 1, 12'h200, 0);  // other opcode
    step("R9", 1, 0, 1, 12'h000, 0);  // empty field
    step("R9", 1, 0, 1, 12'h220, 0);  // two bits
    step("R9", 1, 0, 1, 12'hFFF, 0);  // all bits
    step("R8", 1, 0, 1, 12'h001, 0);  // halt
    step("R8", 1, 0, 1, 12'h200, 0);  // ignored while halted
    step("R8", 1, 0, 1, 12'h004, 0);  // no skip while halted
    step("R8", 0, 0, 0, 12'h000, 1);  // start
    step("R8", 1, 0, 1, 12'h001, 1);  // start wins
    step("R10", 1, 0, 1, 12'h200, 0); // FFFF next edge
    step("R10", 1, 0, 1, 12'h020, 0);
    step("R10", 0, 0, 0, 12'h000, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule